// File: doc/BRIEF.md
# Link-Down Recovery Watchdog

This block watches the status of a serial link and tries to bring it back when it stays down. Each clock it looks at a link-up flag and a loopback-active flag. Loopback might be selected when the link is down. If it is, or if the link is up, an interval timer is held at zero. Once the link has been down, outside loopback, for a full interval, the block starts a logic reset. At that same moment it restarts the timer, so a link that stays dead gets one reset per interval. This is a limited reset. It clears the datapath logic and leaves configuration alone.

The reset appears as a self-clearing command bit, the `lrst_req_o` output, which the reset target sees as a request level. The bit is set when a reset starts and is cleared by hardware when the target returns a completion pulse on `lrst_done_i`. Software can also ask for a reset by presenting a new operating mode word with a strobe. A reset is started only if the word differs from the one last applied, because a needless reset would briefly drop the link. A request that arrives while a reset is outstanding is absorbed into the reset already running.

While a reset is outstanding, a poll monitor checks for completion every `POLL_GAP` cycles, up to `POLL_TRIES` times. If the reset is still pending at the final poll, a sticky timeout flag is raised, and reading the status clears it. A counter of watchdog expiries is kept for software.

Top module: `link_recovery_wd`

## Requirements
- R1: After a synchronous reset, `lrst_req_o`, `timeout_o` and `wd_count_o` are all zero.
- R2: If `link_up_i` and `loopback_i` are both sampled low on `INTERVAL` consecutive rising edges, the watchdog expires on the last of those edges, and `lrst_req_o` is high after that edge.
- R3: Any edge that samples `link_up_i` or `loopback_i` high reloads the interval, so no expiry happens until `INTERVAL` further consecutive down edges have been seen.
- R4: The interval restarts on the same edge that it expires, so a link that stays down expires once every `INTERVAL` edges.
- R5: Once set, `lrst_req_o` stays high until an edge samples `lrst_done_i` high, and it is low after that edge.
- R6: When `reconf_stb_i` is high and `reconf_mode_i` differs from the last mode word applied (zero after reset), a reset starts and `lrst_req_o` is high after that edge. A strobe that carries an unchanged mode word starts nothing. Every strobe records its word as the last applied.
- R7: A watchdog expiry or software request that arrives while `lrst_req_o` is high is merged. `lrst_req_o` stays high with no extra request, and the poll window is not restarted.
- R8: If a reset is still pending after `POLL_GAP*POLL_TRIES` edges following its start, with no completion sampled on those edges, `timeout_o` goes high after that edge and `lrst_req_o` stays high.
- R9: `timeout_o` is sticky. It is low after an edge that samples `stat_rd_i` high, unless a new timeout occurs on that same edge, in which case it stays high.
- R10: `wd_count_o` increases by one on each watchdog expiry, merged ones included, and wraps modulo 2^`CNT_W`.
- R11: A completion pulse on `lrst_done_i` while no reset is pending has no effect, and `lrst_req_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up_i | input | 1 | Link status, high when the link is up |
| loopback_i | input | 1 | High while any loopback mode is selected |
| reconf_stb_i | input | 1 | Strobe that applies a new operating mode word |
| reconf_mode_i | input | MODE_W | Operating mode word applied on the strobe |
| lrst_done_i | input | 1 | Completion pulse from the reset target |
| stat_rd_i | input | 1 | Status read strobe; clears the timeout flag |
| lrst_req_o | output | 1 | Self-clearing logic-reset command bit / request level |
| timeout_o | output | 1 | Sticky reset-completion timeout flag |
| wd_count_o | output | CNT_W | Number of watchdog expiries, wrapping |

## Verification
Four properties are checked on every cycle by the assertions. The command bit holds until a completion arrives and drops right after one. A quiet idle cycle never raises a request. The expiry count never moves after an edge that saw link-up or loopback, and it only ever steps by one. The timeout flag holds until it is read, and it only rises while the reset is still pending. The exact interval length, the restart on expiry, the merging of overlapping requests, the mode comparison and the exact cycle of the timeout can only be shown by the bench's scenarios. There, a reference model is compared with the design after every edge.

// File: rtl/lrw_pkg.sv
package lrw_pkg;
  typedef enum logic {
    MON_IDLE = 1'b0,
    MON_WAIT = 1'b1
  } mon_state_e;

  typedef struct packed {
    logic wd_fire;
    logic sw_req;
  } req_src_t;
endpackage

// File: rtl/lrw_interval_timer.sv
module lrw_interval_timer #(
  parameter int INTERVAL = 500_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic expire_o
);
  localparam int TW = $clog2(INTERVAL + 1);

  logic [TW-1:0] cnt_q;
  logic          at_end;

  assign at_end   = (cnt_q == TW'(INTERVAL - 1));
  assign expire_o = !hold_i && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (hold_i || at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lrw_cmd_ctl.sv
module lrw_cmd_ctl
  import lrw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  req_src_t src_i,
  input  logic     done_i,
  output logic     busy_o,
  output logic     start_o
);
  logic busy_q;
  logic any_req;

  assign any_req = src_i.wd_fire || src_i.sw_req;
  assign start_o = !busy_q && any_req;
  assign busy_o  = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (done_i) busy_q <= 1'b0;
    end else if (any_req) begin
      busy_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lrw_poll_mon.sv
module lrw_poll_mon
  import lrw_pkg::*;
#(
  parameter int POLL_GAP   = 100,
  parameter int POLL_TRIES = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic busy_i,
  input  logic done_i,
  output logic timeout_o
);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int NW = $clog2(POLL_TRIES + 1);

  mon_state_e    state_q;
  logic [GW-1:0] gap_q;
  logic [NW-1:0] tries_q;
  logic          pending;
  logic          poll_tick;
  logic          last_poll;

  assign pending   = (state_q == MON_WAIT) && busy_i && !done_i;
  assign poll_tick = pending && (gap_q == GW'(POLL_GAP - 1));
  assign last_poll = poll_tick && (tries_q == NW'(POLL_TRIES - 1));
  assign timeout_o = last_poll;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MON_IDLE;
      gap_q   <= '0;
      tries_q <= '0;
    end else if (start_i) begin
      state_q <= MON_WAIT;
      gap_q   <= '0;
      tries_q <= '0;
    end else if (state_q == MON_WAIT) begin
      if (!pending || last_poll) begin
        state_q <= MON_IDLE;
      end else if (poll_tick) begin
        gap_q   <= '0;
        tries_q <= tries_q + 1'b1;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/link_recovery_wd.sv
module link_recovery_wd
  import lrw_pkg::*;
#(
  parameter int INTERVAL   = 500_000_000,
  parameter int POLL_GAP   = 100,
  parameter int POLL_TRIES = 50,
  parameter int MODE_W     = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_up_i,
  input  logic              loopback_i,
  input  logic              reconf_stb_i,
  input  logic [MODE_W-1:0] reconf_mode_i,
  input  logic              lrst_done_i,
  input  logic              stat_rd_i,
  output logic              lrst_req_o,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  wd_count_o
);
  logic              hold;
  logic              wd_fire;
  logic              busy;
  logic              start;
  logic              to_ev;
  logic [MODE_W-1:0] last_mode_q;
  logic              timeout_q;
  logic [CNT_W-1:0]  count_q;
  req_src_t          src;

  assign hold = link_up_i || loopback_i;

  lrw_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .hold_i   (hold),
    .expire_o (wd_fire)
  );

  assign src.wd_fire = wd_fire;
  assign src.sw_req  = reconf_stb_i && (reconf_mode_i != last_mode_q);

  lrw_cmd_ctl u_cmd (
    .clk     (clk),
    .rst     (rst),
    .src_i   (src),
    .done_i  (lrst_done_i),
    .busy_o  (busy),
    .start_o (start)
  );

  lrw_poll_mon #(.POLL_GAP(POLL_GAP), .POLL_TRIES(POLL_TRIES)) u_mon (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .busy_i    (busy),
    .done_i    (lrst_done_i),
    .timeout_o (to_ev)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      last_mode_q <= '0;
      timeout_q   <= 1'b0;
      count_q     <= '0;
    end else begin
      if (reconf_stb_i) last_mode_q <= reconf_mode_i;
      if (to_ev)          timeout_q <= 1'b1;
      else if (stat_rd_i) timeout_q <= 1'b0;
      if (wd_fire) count_q <= count_q + 1'b1;
    end
  end

  assign lrst_req_o = busy;
  assign timeout_o  = timeout_q;
  assign wd_count_o = count_q;
endmodule

// File: rtl/lrw_checks.sv
module lrw_checks #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             link_up_i,
  input logic             loopback_i,
  input logic             reconf_stb_i,
  input logic             lrst_done_i,
  input logic             stat_rd_i,
  input logic             lrst_req_o,
  input logic             timeout_o,
  input logic [CNT_W-1:0] wd_count_o
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lrst_req_o && !lrst_done_i |=> lrst_req_o);

  // R5
  req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    lrst_req_o && lrst_done_i |=> !lrst_req_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lrst_req_o && !reconf_stb_i && (link_up_i || loopback_i) |=> !lrst_req_o);

  // R3
  hold_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (link_up_i || loopback_i) |=> $stable(wd_count_o));

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wd_count_o) |-> wd_count_o == CNT_W'($past(wd_count_o) + 1'b1));

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o && !stat_rd_i |=> timeout_o);

  // R8
  timeout_pending_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_o) |-> lrst_req_o);
endmodule

bind link_recovery_wd lrw_checks #(.CNT_W(CNT_W)) u_lrw_checks (
  .clk          (clk),
  .rst          (rst),
  .link_up_i    (link_up_i),
  .loopback_i   (loopback_i),
  .reconf_stb_i (reconf_stb_i),
  .lrst_done_i  (lrst_done_i),
  .stat_rd_i    (stat_rd_i),
  .lrst_req_o   (lrst_req_o),
  .timeout_o    (timeout_o),
  .wd_count_o   (wd_count_o)
);

// File: tb/link_recovery_wd_bench.sv
module link_recovery_wd_bench;
  localparam int INTERVAL = 24;
  localparam int GAP      = 3;
  localparam int TRIES    = 5;
  localparam int MODE_W   = 4;
  localparam int CNT_W    = 3;

  logic clk = 0;
  logic rst = 1;
  logic link_up = 1, loopback = 0, stb = 0, rd = 0;
  logic [MODE_W-1:0] mode = '0;
  logic resp_done = 0, man_done = 0;
  logic done;
  logic req, tout;
  logic [CNT_W-1:0] cnt;

  assign done = resp_done | man_done;
  always #5 clk = ~clk;

  link_recovery_wd #(
    .INTERVAL(INTERVAL), .POLL_GAP(GAP), .POLL_TRIES(TRIES),
    .MODE_W(MODE_W), .CNT_W(CNT_W)
  ) u_link_recovery_wd (
    .clk(clk), .rst(rst), .link_up_i(link_up), .loopback_i(loopback),
    .reconf_stb_i(stb), .reconf_mode_i(mode), .lrst_done_i(done),
    .stat_rd_i(rd), .lrst_req_o(req), .timeout_o(tout), .wd_count_o(cnt)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model, updated on every rising edge
  int m_busy = 0, m_run = 0, m_act = 0, m_elapsed = 0, m_to = 0, m_cnt = 0, m_last = 0;
  always @(posedge clk) begin
    int fire, swreq, to_ev;
    if (rst) begin
      m_busy = 0; m_run = 0; m_act = 0; m_elapsed = 0; m_to = 0; m_cnt = 0; m_last = 0;
    end else begin
      fire = 0; to_ev = 0;
      if (link_up || loopback) m_run = 0;
      else begin
        m_run++;
        if (m_run == INTERVAL) begin fire = 1; m_run = 0; end
      end
      swreq = (stb && int'(mode) != m_last) ? 1 : 0;
      if (stb) m_last = int'(mode);
      if (m_act != 0) begin
        if (m_busy == 0 || done) m_act = 0;
        else begin
          m_elapsed++;
          if (m_elapsed == GAP * TRIES) begin to_ev = 1; m_act = 0; end
        end
      end
      if (m_busy != 0) begin
        if (done) m_busy = 0;
      end else if (fire != 0 || swreq != 0) begin
        m_busy = 1; m_act = 1; m_elapsed = 0;
      end
      if (to_ev != 0) m_to = 1;
      else if (rd) m_to = 0;
      if (fire != 0) m_cnt = (m_cnt + 1) % (1 << CNT_W);
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(req == (m_busy != 0), "R5 request level vs model", int'(req), m_busy);
      chk(tout == (m_to != 0), "R8 timeout flag vs model", int'(tout), m_to);
      chk(int'(cnt) == m_cnt, "R10 expiry count vs model", int'(cnt), m_cnt);
    end
  end

  // Reset target responder
  bit resp_en = 1;
  int resp_lat = 4;
  int lat = 0;
  always @(negedge clk) begin
    resp_done = 0;
    if (resp_en && req) begin
      if (lat == resp_lat) begin resp_done = 1; lat = 0; end
      else lat++;
    end else if (!req) lat = 0;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    // R1
    chk(req == 0 && tout == 0 && cnt == 0, "R1 reset state", int'({req, tout, cnt}), 0);

    // R2: expiry after exactly INTERVAL down edges
    link_up = 0;
    cyc(INTERVAL - 1);
    chk(req == 0, "R2 no request before interval", int'(req), 0);
    cyc(1);
    link_up = 1;
    chk(req == 1, "R2 request after interval", int'(req), 1);
    chk(cnt == 1, "R2 expiry counted", int'(cnt), 1);
    cyc(10);
    // R5
    chk(req == 0, "R5 request cleared by completion", int'(req), 0);

    // R3: interruptions reload the interval
    link_up = 0; cyc(INTERVAL - 4);
    link_up = 1; cyc(1);
    link_up = 0; cyc(INTERVAL - 4);
    loopback = 1; cyc(INTERVAL + 6);
    loopback = 0; link_up = 1; cyc(1);
    chk(cnt == 1 && req == 0, "R3 reload prevents expiry", int'(cnt), 1);

    // R4: repeated expiry while down
    link_up = 0; cyc(2 * INTERVAL);
    link_up = 1;
    chk(cnt == 3, "R4 one expiry per interval", int'(cnt), 3);
    cyc(10);

    // R8: no completion -> timeout
    resp_en = 0;
    link_up = 0; cyc(INTERVAL);
    link_up = 1;
    chk(req == 1 && cnt == 4, "R8 reset started", int'(cnt), 4);
    cyc(GAP * TRIES - 1);
    chk(tout == 0, "R8 no timeout before window", int'(tout), 0);
    cyc(1);
    chk(tout == 1, "R8 timeout at window end", int'(tout), 1);
    chk(req == 1, "R8 request still pending", int'(req), 1);

    // R7: merged expiry while busy
    link_up = 0; cyc(INTERVAL);
    link_up = 1;
    chk(cnt == 5 && req == 1, "R7 merged expiry counted, request held", int'(cnt), 5);
    // R9
    chk(tout == 1, "R9 timeout sticky without read", int'(tout), 1);
    rd = 1; cyc(1); rd = 0;
    chk(tout == 0, "R9 read clears timeout", int'(tout), 0);
    resp_en = 1; cyc(10);
    chk(req == 0 && tout == 0, "R7 merged reset did not re-arm timeout", int'(tout), 0);

    // R10: wrap of the expiry count
    link_up = 0; cyc(3 * INTERVAL);
    link_up = 1;
    chk(cnt == 0, "R10 count wraps", int'(cnt), 0);
    cyc(10);

    // R6: mode comparison
    mode = 4'd0; stb = 1; cyc(1); stb = 0;
    cyc(2);
    chk(req == 0, "R6 unchanged mode starts nothing", int'(req), 0);
    mode = 4'd5; stb = 1; cyc(1); stb = 0;
    chk(req == 1, "R6 changed mode starts reset", int'(req), 1);
    cyc(10);
    stb = 1; cyc(1); stb = 0;
    chk(req == 0, "R6 repeat of applied mode ignored", int'(req), 0);

    // R11: stray completion while idle
    man_done = 1; cyc(1); man_done = 0;
    cyc(1);
    chk(req == 0 && cnt == 0, "R11 idle completion ignored", int'(req), 0);

    cyc(5);
    summary();
  end
endmodule